// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Detector

This block turns a stream of sampled pin vectors into per-pin interrupt status and a single interrupt request. The pins are grouped in banks of 32. Each bank has an enable register, three trigger-type bit-planes and a write-one-to-clear status register. An upstream serial engine presents a complete sampled vector together with a one-cycle valid strobe. On every accepted sample, each enabled pin is evaluated against the trigger mode programmed for it. The block keeps the previous sample so that it can detect edges.

Two of the bit-planes choose between edge and level and pick the polarity. The third turns an edge-triggered pin into a dual-edge pin. Status bits collect the hits. The interrupt output is the OR of every pending status bit whose enable is set. The sample input is a valid-only stream: the block accepts a sample in every cycle where the strobe is high and never applies back-pressure, so there is no ready signal. Register access is a plain single-cycle write port with a combinational read port.

Top module: `trig_irq_detect`

## Requirements
- R1: After reset every enable, type and status register reads 0 and `irq` is 0.
- R2: Bank b has interrupt base 0x04 + 0x1C*b. Enable is at base+0x00, type0 at +0x04, type1 at +0x08, type2 at +0x0C and status at +0x10. A write to enable or to a type register is read back unchanged. Every other address reads 0.
- R3: With type1=0, type0=1 and type2=0, a 0-to-1 change between consecutive samples on an enabled pin sets its status bit.
- R4: With type1=0, type0=0 and type2=0, a 1-to-0 change between consecutive samples on an enabled pin sets its status bit.
- R5: With type1=0 and type2=1, a change in either direction sets the status bit, whatever type0 holds.
- R6: With type1=1 the pin is level-triggered: active high when type0=1 and active low when type0=0. Every accepted sample at the active level sets the status bit again, even if it was just cleared.
- R7: A status write clears each bit written as 1 and leaves each bit written as 0 unchanged. A status write never sets a bit.
- R8: A pin whose enable bit is 0 in the cycle of the sample never sets its status bit.
- R9: `irq` equals the OR over all banks of status AND enable. A pending bit whose enable is 0 does not drive `irq`.
- R10: When a status clear and a new hit on the same bit fall in the same cycle, the bit ends set.
- R11: Status bits are set only in cycles where `samp_valid` is high. The first accepted sample after reset only sets the edge baseline and produces no edge hits.
- R12: A hit becomes visible in status, and in `irq`, in the cycle after the sample strobe, not in the strobe cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Sampled vector valid strobe, accepted every cycle |
| samp_data | input | NUM_BANKS*BANK_W | Sampled pin vector; bank b occupies bits [b*32 +: 32] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for both read and write |
| reg_wdata | input | BANK_W | Register write data |
| reg_rdata | output | BANK_W | Combinational read data for reg_addr |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check four things on every cycle: `irq` tracks the enabled pending bits, a status bit rises only on a sample strobe and only where the pin was enabled, a status bit falls only on a register write, and reset clears both status and `irq`. The bench scenarios show what a per-cycle property cannot express compactly. These include the choice of edge polarity, dual-edge operation that ignores type0, level re-assertion after a clear, the first-sample baseline, a set that wins over a simultaneous clear, and the one-cycle latency. A reference model is run on constrained random register and sample traffic.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // register field selected inside one bank window
  typedef enum logic [2:0] {
    FLD_EN   = 3'd0,
    FLD_T0   = 3'd1,
    FLD_T1   = 3'd2,
    FLD_T2   = 3'd3,
    FLD_ST   = 3'd4,
    FLD_NONE = 3'd7
  } trig_fld_e;

  // word offsets of the fields within a bank window
  localparam int OFF_LAST = 'h10;
endpackage

// File: rtl/trig_addr_dec.sv
module trig_addr_dec
  import trig_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int ADDR_W      = 8,
  parameter int IRQ_BASE0   = 'h04,
  parameter int BANK_STRIDE = 'h1C
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_sel,
  output trig_fld_e            fld
);
  logic [NUM_BANKS-1:0] hit;
  trig_fld_e            fld_b [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
    localparam int BASE = IRQ_BASE0 + b * BANK_STRIDE;
    logic [ADDR_W:0] diff;
    assign diff   = {1'b0, addr} - (ADDR_W+1)'(BASE);
    assign hit[b] = !diff[ADDR_W] && (diff[ADDR_W-1:0] <= ADDR_W'(OFF_LAST))
                    && (diff[1:0] == 2'b00);
    always_comb begin
      case (diff[4:2])
        3'd0:    fld_b[b] = FLD_EN;
        3'd1:    fld_b[b] = FLD_T0;
        3'd2:    fld_b[b] = FLD_T1;
        3'd3:    fld_b[b] = FLD_T2;
        3'd4:    fld_b[b] = FLD_ST;
        default: fld_b[b] = FLD_NONE;
      endcase
    end
  end

  always_comb begin
    bank_sel = hit;
    fld      = FLD_NONE;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit[b]) fld = fld_b[b];
    end
  end
endmodule

// File: rtl/trig_edge_track.sv
module trig_edge_track #(
  parameter int PINS = 96
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            samp_valid,
  input  logic [PINS-1:0] samp_data,
  output logic [PINS-1:0] prev_q,
  output logic            primed_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (samp_valid) begin
      prev_q   <= samp_data;
      primed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  trig_fld_e         fld,
  input  logic [BANK_W-1:0] wdata,
  input  logic              samp_valid,
  input  logic [BANK_W-1:0] cur,
  input  logic [BANK_W-1:0] prev,
  input  logic              primed,
  output logic [BANK_W-1:0] en_q,
  output logic [BANK_W-1:0] t0_q,
  output logic [BANK_W-1:0] t1_q,
  output logic [BANK_W-1:0] t2_q,
  output logic [BANK_W-1:0] st_q
);
  logic [BANK_W-1:0] rise, fall, edge_hit, lvl_hit, hit, set_v, clr_v;

  always_comb begin
    rise     = primed ? (cur & ~prev) : '0;
    fall     = primed ? (~cur & prev) : '0;
    edge_hit = (t2_q & (rise | fall)) | (~t2_q & t0_q & rise) | (~t2_q & ~t0_q & fall);
    lvl_hit  = (t0_q & cur) | (~t0_q & ~cur);
    hit      = (t1_q & lvl_hit) | (~t1_q & edge_hit);
    set_v    = samp_valid ? (hit & en_q) : '0;
    clr_v    = (wr && fld == FLD_ST) ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      t0_q <= '0;
      t1_q <= '0;
      t2_q <= '0;
      st_q <= '0;
    end else begin
      if (wr) begin
        case (fld)
          FLD_EN:  en_q <= wdata;
          FLD_T0:  t0_q <= wdata;
          FLD_T1:  t1_q <= wdata;
          FLD_T2:  t2_q <= wdata;
          default: ;
        endcase
      end
      st_q <= (st_q & ~clr_v) | set_v;
    end
  end
endmodule

// File: rtl/trig_irq_or.sv
module trig_irq_or #(
  parameter int PINS = 96
) (
  input  logic [PINS-1:0] status,
  input  logic [PINS-1:0] enable,
  output logic            irq
);
  assign irq = |(status & enable);
endmodule

// File: rtl/trig_irq_detect.sv
module trig_irq_detect
  import trig_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int IRQ_BASE0   = 'h04,
  parameter int BANK_STRIDE = 'h1C
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        samp_valid,
  input  logic [NUM_BANKS*BANK_W-1:0] samp_data,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [BANK_W-1:0]           reg_wdata,
  output logic [BANK_W-1:0]           reg_rdata,
  output logic                        irq
);
  localparam int PINS = NUM_BANKS * BANK_W;

  logic [NUM_BANKS-1:0] bank_sel;
  trig_fld_e            fld;
  logic [PINS-1:0]      prev_q;
  logic                 primed_q;
  logic [PINS-1:0]      status_all, enable_all;
  logic [BANK_W-1:0]    en_b [NUM_BANKS];
  logic [BANK_W-1:0]    t0_b [NUM_BANKS];
  logic [BANK_W-1:0]    t1_b [NUM_BANKS];
  logic [BANK_W-1:0]    t2_b [NUM_BANKS];
  logic [BANK_W-1:0]    st_b [NUM_BANKS];

  trig_addr_dec #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W),
    .IRQ_BASE0(IRQ_BASE0), .BANK_STRIDE(BANK_STRIDE)
  ) u_dec (
    .addr(reg_addr), .bank_sel(bank_sel), .fld(fld)
  );

  trig_edge_track #(.PINS(PINS)) u_track (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid),
    .samp_data(samp_data), .prev_q(prev_q), .primed_q(primed_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    trig_bank #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_we && bank_sel[b]), .fld(fld), .wdata(reg_wdata),
      .samp_valid(samp_valid),
      .cur(samp_data[b*BANK_W +: BANK_W]),
      .prev(prev_q[b*BANK_W +: BANK_W]),
      .primed(primed_q),
      .en_q(en_b[b]), .t0_q(t0_b[b]), .t1_q(t1_b[b]),
      .t2_q(t2_b[b]), .st_q(st_b[b])
    );
    assign status_all[b*BANK_W +: BANK_W] = st_b[b];
    assign enable_all[b*BANK_W +: BANK_W] = en_b[b];
  end

  trig_irq_or #(.PINS(PINS)) u_or (
    .status(status_all), .enable(enable_all), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) begin
        case (fld)
          FLD_EN:  reg_rdata = en_b[b];
          FLD_T0:  reg_rdata = t0_b[b];
          FLD_T1:  reg_rdata = t1_b[b];
          FLD_T2:  reg_rdata = t2_b[b];
          FLD_ST:  reg_rdata = st_b[b];
          default: reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/trig_irq_detect_chk.sv
module trig_irq_detect_chk #(
  parameter int PINS = 96
) (
  input logic            clk,
  input logic            rst_n,
  input logic            samp_valid,
  input logic            reg_we,
  input logic            irq,
  input logic [PINS-1:0] status_all,
  input logic [PINS-1:0] enable_all
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (status_all == '0 && irq == 1'b0));

  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(status_all & enable_all));

  // R8
  no_set_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_all & ~$past(status_all) & ~$past(enable_all)) == '0));

  // R11
  set_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(samp_valid) |-> ((status_all & ~$past(status_all)) == '0));

  // R7
  clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we) |-> (($past(status_all) & ~status_all) == '0));
endmodule

bind trig_irq_detect trig_irq_detect_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .reg_we(reg_we),
  .irq(irq), .status_all(status_all), .enable_all(enable_all)
);

// File: tb/test_trig_irq_detect.sv
`timescale 1ns/1ps
module test_trig_irq_detect;
  localparam int NB = 3;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          samp_valid = 1'b0;
  logic [NB*W-1:0] samp_data = '0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [W-1:0]  reg_wdata = '0;
  logic [W-1:0]  reg_rdata;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  trig_irq_detect i_trig_irq_detect (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // reference model state
  logic [W-1:0] m_en [NB], m_t0 [NB], m_t1 [NB], m_t2 [NB], m_st [NB];
  logic [NB*W-1:0] m_prev;
  bit m_primed;
  logic [NB*W-1:0] cur_in;

  function automatic int base_of(int b);
    return 'h04 + 'h1C * b;
  endfunction

  function automatic logic [W-1:0] model_read(logic [7:0] a);
    logic [W-1:0] r = '0;
    for (int b = 0; b < NB; b++) begin
      int d = int'(a) - base_of(b);
      case (d)
        'h00: r = m_en[b];
        'h04: r = m_t0[b];
        'h08: r = m_t1[b];
        'h0C: r = m_t2[b];
        'h10: r = m_st[b];
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic logic model_irq();
    logic v = 1'b0;
    for (int b = 0; b < NB; b++) v |= |(m_st[b] & m_en[b]);
    return v;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, optionally compare before the edge, advance model
  task automatic step(input bit we, input logic [7:0] a, input logic [W-1:0] wd,
                      input bit sv, input logic [NB*W-1:0] sd,
                      input bit ck, input string tag);
    logic [W-1:0] n_st [NB];
    logic [W-1:0] rise, fall, eh, lh, hit, clr, cur, prv;
    reg_we = we; reg_addr = a; reg_wdata = wd; samp_valid = sv; samp_data = sd;
    #1;
    if (ck) begin
      chk(tag, reg_rdata, model_read(a));
      chk({tag, " irq R9"}, {31'd0, irq}, {31'd0, model_irq()});
    end
    for (int b = 0; b < NB; b++) begin
      cur = sd[b*W +: W];
      prv = m_prev[b*W +: W];
      rise = m_primed ? (cur & ~prv) : '0;
      fall = m_primed ? (~cur & prv) : '0;
      for (int p = 0; p < W; p++) begin
        eh[p] = m_t2[b][p] ? (rise[p] | fall[p]) : (m_t0[b][p] ? rise[p] : fall[p]);
        lh[p] = m_t0[b][p] ? cur[p] : ~cur[p];
        hit[p] = m_t1[b][p] ? lh[p] : eh[p];
      end
      clr = (we && int'(a) == base_of(b) + 'h10) ? wd : '0;
      n_st[b] = (m_st[b] & ~clr) | (sv ? (hit & m_en[b]) : '0);
    end
    @(posedge clk);
    for (int b = 0; b < NB; b++) begin
      m_st[b] = n_st[b];
      if (we) begin
        if (int'(a) == base_of(b))        m_en[b] = wd;
        if (int'(a) == base_of(b) + 'h04) m_t0[b] = wd;
        if (int'(a) == base_of(b) + 'h08) m_t1[b] = wd;
        if (int'(a) == base_of(b) + 'h0C) m_t2[b] = wd;
      end
    end
    if (sv) begin m_prev = sd; m_primed = 1; cur_in = sd; end
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [W-1:0] d);
    step(1, a, d, 0, cur_in, 0, "");
  endtask
  task automatic rd(logic [7:0] a, string tag);
    step(0, a, '0, 0, cur_in, 1, tag);
  endtask
  task automatic smp(logic [NB*W-1:0] d);
    step(0, 8'h00, '0, 1, d, 0, "");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_en[b] = '0; m_t0[b] = '0; m_t1[b] = '0; m_t2[b] = '0; m_st[b] = '0;
    end
    m_prev = '0; m_primed = 0; cur_in = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every mapped register starts at zero
    for (int b = 0; b < NB; b++)
      for (int o = 0; o <= 'h10; o += 4) rd(8'(base_of(b) + o), "R1");

    // R2: read back of enable/type, unmapped reads zero
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h04, "R2"); rd(8'h08, "R2");
    wr(8'h44, 32'h1234_5678); rd(8'h44, "R2"); wr(8'h44, 32'h0);
    rd(8'h00, "R2"); rd(8'h50, "R2"); rd(8'h16, "R2");

    // R11: first sample only sets the baseline
    smp({64'h0, 32'hFFFF_FFFF});
    rd(8'h14, "R11");

    // R3 rising, R12 latency (status still old in the strobe cycle)
    smp('0);
    step(0, 8'h14, '0, 1, {64'h0, 32'hFFFF_FFFF}, 1, "R12");
    rd(8'h14, "R3");

    // R7 partial clear and zero write
    wr(8'h14, 32'h0000_FFFF); rd(8'h14, "R7");
    wr(8'h14, 32'h0);         rd(8'h14, "R7");
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, "R7");

    // R4 falling on bank 1
    wr(8'h20, 32'hFFFF_FFFF);
    smp({32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF});
    smp({32'h0, 32'h0F0F_0000, 32'hFFFF_FFFF});
    rd(8'h30, "R4");

    // R5 dual edge on bank 2 with type0=0
    wr(8'h3C, 32'h0000_000F); wr(8'h48, 32'h0000_000F);
    smp({32'h0000_0003, 32'h0F0F_0000, 32'hFFFF_FFFF});
    rd(8'h4C, "R5");
    wr(8'h4C, 32'hFFFF_FFFF);
    smp({32'h0000_0000, 32'h0F0F_0000, 32'hFFFF_FFFF});
    rd(8'h4C, "R5");

    // R6 level high then low on bank 0
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
    smp({32'h0, 32'h0F0F_0000, 32'h0000_00F0});
    rd(8'h14, "R6");
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, "R6");
    smp({32'h0, 32'h0F0F_0000, 32'h0000_00F0});
    rd(8'h14, "R6");
    wr(8'h08, 32'h0); wr(8'h14, 32'hFFFF_FFFF);
    smp({32'h0, 32'h0F0F_0000, 32'h0000_00F0});
    rd(8'h14, "R6");

    // R8 only enabled pin of bank 1 may set
    wr(8'h20, 32'h0000_0001); wr(8'h30, 32'hFFFF_FFFF);
    smp({32'h0, 32'hF0F0_FFFE, 32'h0000_00F0});
    smp({32'h0, 32'h0F0F_0001, 32'h0000_00F0});
    rd(8'h30, "R8");

    // R9 pending bits with enable removed
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0);
    rd(8'h14, "R9");

    // R10 clear and new hit in the same cycle
    smp({32'h0000_0000, 32'h0F0F_0001, 32'h0000_00F0});
    wr(8'h4C, 32'hFFFF_FFFF);
    step(1, 8'h4C, 32'hFFFF_FFFF, 1, {32'h0000_0005, 32'h0F0F_0001, 32'h0000_00F0}, 0, "");
    rd(8'h4C, "R10");

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom % 10;
      int b  = $urandom % NB;
      logic [7:0] a = 8'(base_of(b) + 4 * ($urandom % 5));
      if (op < 3) begin
        logic [W-1:0] d = $urandom;
        if (a == 8'(base_of(b) + 'h10) && ($urandom % 2)) d = d & $urandom;
        step(1, a, d, ($urandom % 3) == 0,
             cur_in ^ {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
                       $urandom & $urandom & $urandom}, 1, "R2 rnd");
      end else if (op < 7) begin
        step(0, a, '0, 1,
             cur_in ^ {$urandom & $urandom, $urandom & $urandom, $urandom & $urandom},
             1, "R6 rnd");
      end else begin
        rd(((op == 9) && ($urandom % 4 == 0)) ? 8'h5C : a, "R7 rnd");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule